// File: doc/BRIEF.md
# Command-Driven Nibble Register ALU

This block is a small accumulator-style datapath. On each clock it can execute one command taken from a fixed set of ten, applied to a data operand. It holds two working registers (A and B), a flag register and a one-bit mode register. Loads place the operand in A or B, and moves copy B or the flag register into A. An emit command presents A on a registered output bus. The four arithmetic and logic commands combine A with B and always write the result back into A.

A controller issues commands by raising a valid strobe for one cycle with a command code and an operand. Codes outside the set are dropped without effect, and so is any cycle with the strobe low. The mode register chooses between wrapping and saturating arithmetic. All four registers are visible on dedicated debug outputs. They can also be read through an index-selected debug port.

Top module: `nib_cmd_alu`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, A, B, the flag register, the mode register, `out_o` and `out_vld_o` are all cleared to zero at that edge (synchronous reset).
- R2: A cycle with `cmd_vld_i` low, or with a command code from 10 to 15, leaves A, B, the flag register and the mode register unchanged.
- R3: Code 0 writes `data_i` into A, and code 1 writes `data_i` into B, at the next rising edge.
- R4: Code 3 copies B into A, and code 4 copies the 4-bit flag register into A.
- R5: Code 2 captures the current value of A into `out_o` and drives `out_vld_o` high for exactly the one cycle after the command's edge. `out_vld_o` is low after any cycle without code 2.
- R6: Code 5 writes A+B into A, and code 6 writes A−B into A. Both wrap modulo 16 when the mode register is 0.
- R7: Code 7 writes A AND B into A, and code 8 writes A OR B into A.
- R8: The flag register is laid out as bit 3 overflow (signed), bit 2 negative (result bit 3), bit 1 zero, bit 0 carry. It changes only on codes 5 to 8. For subtraction, carry means no borrow (A ≥ B). Codes 7 and 8 clear carry and overflow.
- R9: When the mode register is 1, an addition that carries writes 15 into A, and a subtraction that borrows writes 0 into A. The flags still describe the unsaturated result.
- R10: Code 9 loads bit 0 of `data_i` into the mode register. The other bits of the operand are ignored.
- R11: `dbg_data_o` shows A for index 0x00, B for 0x01, the mode register (zero-extended) for 0x02, and the flag register for 0x03. Any other index reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_vld_i | input | 1 | Command valid strobe |
| cmd_i | input | 4 | Command code |
| data_i | input | DW (4) | Data operand |
| dbg_idx_i | input | IDX_W (8) | Debug register index |
| out_o | output | DW (4) | Registered output bus |
| out_vld_o | output | 1 | Output valid pulse |
| dbg_data_o | output | DW (4) | Indexed debug read data |
| reg_a_o | output | DW (4) | Register A |
| reg_b_o | output | DW (4) | Register B |
| flag_o | output | 4 | Flag register {overflow, negative, zero, carry} |
| mode_o | output | 1 | Mode register (1 = saturate) |

## Verification
Several properties are checked on every cycle. The output pulse must trace back to an emit command and carry A's earlier value. Idle and illegal cycles must leave the register file unchanged, and loads, copies and mode writes must land in the right register. The flags must hold across non-ALU commands, logical results must clear carry and overflow, and saturating arithmetic must never move A in the wrong direction. The exact arithmetic and flag values cannot be shown by the properties alone; that needs the bench scenarios. These cover signed-overflow boundaries, the carry at 15+1, a saturating add and subtract, mode loads with upper operand bits set, back-to-back emits, reset in the middle of traffic and out-of-range debug indices.

// File: rtl/nca_pkg.sv
package nca_pkg;

   // Command codes; the numeric values are the external encoding.
   typedef enum logic [3:0] {
      OP_LOAD_A    = 4'd0,
      OP_LOAD_B    = 4'd1,
      OP_EMIT_A    = 4'd2,
      OP_COPY_B    = 4'd3,
      OP_COPY_FLAG = 4'd4,
      OP_ADD       = 4'd5,
      OP_SUB       = 4'd6,
      OP_AND       = 4'd7,
      OP_OR        = 4'd8,
      OP_SET_MODE  = 4'd9
   } op_e;

   localparam int OP_W = 4;
   localparam int FLAG_W = 4;

   // Debug index identifiers.
   localparam int ID_REG_A = 0;
   localparam int ID_REG_B = 1;
   localparam int ID_MODE  = 2;
   localparam int ID_FLAG  = 3;

   typedef struct packed {
      logic ovf;
      logic neg;
      logic zero;
      logic carry;
   } flags_t;

   typedef enum logic [1:0] {
      A_FROM_DATA = 2'd0,
      A_FROM_B    = 2'd1,
      A_FROM_FLAG = 2'd2,
      A_FROM_ALU  = 2'd3
   } a_src_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_SUB = 2'd1,
      FN_AND = 2'd2,
      FN_OR  = 2'd3
   } alu_fn_e;

   typedef struct packed {
      logic    wr_a;
      a_src_e  a_src;
      logic    wr_b;
      logic    wr_flag;
      logic    wr_mode;
      logic    emit;
      alu_fn_e fn;
   } ctrl_t;

endpackage

// File: rtl/nca_decode.sv
module nca_decode
   import nca_pkg::*;
(
   input  logic            vld_i,
   input  logic [OP_W-1:0] code_i,
   output ctrl_t           ctrl_o
);

   always_comb begin
      ctrl_o       = '0;
      ctrl_o.a_src = A_FROM_DATA;
      ctrl_o.fn    = FN_ADD;
      if (vld_i) begin
         case (code_i)
            OP_LOAD_A: begin
               ctrl_o.wr_a  = 1'b1;
               ctrl_o.a_src = A_FROM_DATA;
            end
            OP_LOAD_B: ctrl_o.wr_b = 1'b1;
            OP_EMIT_A: ctrl_o.emit = 1'b1;
            OP_COPY_B: begin
               ctrl_o.wr_a  = 1'b1;
               ctrl_o.a_src = A_FROM_B;
            end
            OP_COPY_FLAG: begin
               ctrl_o.wr_a  = 1'b1;
               ctrl_o.a_src = A_FROM_FLAG;
            end
            OP_ADD, OP_SUB, OP_AND, OP_OR: begin
               ctrl_o.wr_a    = 1'b1;
               ctrl_o.a_src   = A_FROM_ALU;
               ctrl_o.wr_flag = 1'b1;
               case (code_i)
                  OP_ADD:  ctrl_o.fn = FN_ADD;
                  OP_SUB:  ctrl_o.fn = FN_SUB;
                  OP_AND:  ctrl_o.fn = FN_AND;
                  default: ctrl_o.fn = FN_OR;
               endcase
            end
            OP_SET_MODE: ctrl_o.wr_mode = 1'b1;
            default: ; // codes 10..15: no effect
         endcase
      end
   end

endmodule

// File: rtl/nca_alu.sv
module nca_alu
   import nca_pkg::*;
#(
   parameter int DW     = 4,
   parameter bit SAT_EN = 1'b1
)(
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  alu_fn_e       fn_i,
   input  logic          sat_i,
   output logic [DW-1:0] res_o,
   output flags_t        flags_o
);

   localparam int MSB = DW - 1;

   logic [DW:0]   sum_w;
   logic [DW:0]   dif_w;
   logic [DW-1:0] raw_w;
   logic          cy_w;
   logic          ov_w;

   always_comb begin
      sum_w = {1'b0, a_i} + {1'b0, b_i};
      dif_w = {1'b0, a_i} - {1'b0, b_i};
      raw_w = sum_w[DW-1:0];
      cy_w  = 1'b0;
      ov_w  = 1'b0;
      case (fn_i)
         FN_ADD: begin
            raw_w = sum_w[DW-1:0];
            cy_w  = sum_w[DW];
            ov_w  = (a_i[MSB] == b_i[MSB]) && (raw_w[MSB] != a_i[MSB]);
         end
         FN_SUB: begin
            raw_w = dif_w[DW-1:0];
            cy_w  = ~dif_w[DW];
            ov_w  = (a_i[MSB] != b_i[MSB]) && (raw_w[MSB] != a_i[MSB]);
         end
         FN_AND: raw_w = a_i & b_i;
         default: raw_w = a_i | b_i;
      endcase
      flags_o.ovf   = ov_w;
      flags_o.neg   = raw_w[MSB];
      flags_o.zero  = (raw_w == '0);
      flags_o.carry = cy_w;
   end

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            res_o = raw_w;
            if (sat_i) begin
               if (fn_i == FN_ADD && cy_w)
                  res_o = '1;
               else if (fn_i == FN_SUB && !cy_w)
                  res_o = '0;
            end
         end
      end else begin : g_wrap
         logic unused_sat;
         assign unused_sat = sat_i;
         assign res_o = raw_w;
      end
   endgenerate

endmodule

// File: rtl/nca_regs.sv
module nca_regs
   import nca_pkg::*;
#(
   parameter int DW = 4
)(
   input  logic          clk_i,
   input  logic          rst_i,
   input  ctrl_t         ctrl_i,
   input  logic [DW-1:0] data_i,
   input  logic [DW-1:0] alu_res_i,
   input  flags_t        alu_flags_i,
   output logic [DW-1:0] a_o,
   output logic [DW-1:0] b_o,
   output flags_t        flag_o,
   output logic          mode_o,
   output logic [DW-1:0] out_o,
   output logic          out_vld_o
);

   logic [DW-1:0] a_next;

   always_comb begin
      case (ctrl_i.a_src)
         A_FROM_DATA: a_next = data_i;
         A_FROM_B:    a_next = b_o;
         A_FROM_FLAG: a_next = DW'(flag_o);
         default:     a_next = alu_res_i;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         a_o       <= '0;
         b_o       <= '0;
         flag_o    <= '0;
         mode_o    <= 1'b0;
         out_o     <= '0;
         out_vld_o <= 1'b0;
      end else begin
         out_vld_o <= ctrl_i.emit;
         if (ctrl_i.emit)    out_o  <= a_o;
         if (ctrl_i.wr_a)    a_o    <= a_next;
         if (ctrl_i.wr_b)    b_o    <= data_i;
         if (ctrl_i.wr_flag) flag_o <= alu_flags_i;
         if (ctrl_i.wr_mode) mode_o <= data_i[0];
      end
   end

endmodule

// File: rtl/nca_dbg_mux.sv
module nca_dbg_mux
   import nca_pkg::*;
#(
   parameter int DW    = 4,
   parameter int IDX_W = 8
)(
   input  logic [IDX_W-1:0] idx_i,
   input  logic [DW-1:0]    a_i,
   input  logic [DW-1:0]    b_i,
   input  logic             mode_i,
   input  flags_t           flag_i,
   output logic [DW-1:0]    data_o
);

   always_comb begin
      if (idx_i == IDX_W'(ID_REG_A))
         data_o = a_i;
      else if (idx_i == IDX_W'(ID_REG_B))
         data_o = b_i;
      else if (idx_i == IDX_W'(ID_MODE))
         data_o = DW'(mode_i);
      else if (idx_i == IDX_W'(ID_FLAG))
         data_o = DW'(flag_i);
      else
         data_o = '0;
   end

endmodule

// File: rtl/nib_cmd_alu.sv
module nib_cmd_alu
   import nca_pkg::*;
#(
   parameter int DW     = 4,
   parameter int IDX_W  = 8,
   parameter bit SAT_EN = 1'b1
)(
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 cmd_vld_i,
   input  logic [3:0]           cmd_i,
   input  logic [DW-1:0]        data_i,
   input  logic [IDX_W-1:0]     dbg_idx_i,
   output logic [DW-1:0]        out_o,
   output logic                 out_vld_o,
   output logic [DW-1:0]        dbg_data_o,
   output logic [DW-1:0]        reg_a_o,
   output logic [DW-1:0]        reg_b_o,
   output logic [FLAG_W-1:0]    flag_o,
   output logic                 mode_o
);

   generate
      if (DW < FLAG_W) begin : g_bad_dw
         $error("nib_cmd_alu: DW must be at least the flag width");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("nib_cmd_alu: IDX_W must cover four register ids");
      end
   endgenerate

   ctrl_t         ctrl_w;
   logic [DW-1:0] alu_res_w;
   flags_t        alu_flags_w;
   flags_t        flag_q;

   nca_decode u_decode (
      .vld_i  (cmd_vld_i),
      .code_i (cmd_i),
      .ctrl_o (ctrl_w)
   );

   nca_alu #(.DW(DW), .SAT_EN(SAT_EN)) u_alu (
      .a_i     (reg_a_o),
      .b_i     (reg_b_o),
      .fn_i    (ctrl_w.fn),
      .sat_i   (mode_o),
      .res_o   (alu_res_w),
      .flags_o (alu_flags_w)
   );

   nca_regs #(.DW(DW)) u_regs (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .ctrl_i      (ctrl_w),
      .data_i      (data_i),
      .alu_res_i   (alu_res_w),
      .alu_flags_i (alu_flags_w),
      .a_o         (reg_a_o),
      .b_o         (reg_b_o),
      .flag_o      (flag_q),
      .mode_o      (mode_o),
      .out_o       (out_o),
      .out_vld_o   (out_vld_o)
   );

   assign flag_o = flag_q;

   nca_dbg_mux #(.DW(DW), .IDX_W(IDX_W)) u_dbg (
      .idx_i  (dbg_idx_i),
      .a_i    (reg_a_o),
      .b_i    (reg_b_o),
      .mode_i (mode_o),
      .flag_i (flag_q),
      .data_o (dbg_data_o)
   );

endmodule

// File: rtl/nca_checker.sv
module nca_checker #(
   parameter int DW     = 4,
   parameter bit SAT_EN = 1'b1
)(
   input logic          clk_i,
   input logic          rst_i,
   input logic          cmd_vld_i,
   input logic [3:0]    cmd_i,
   input logic [DW-1:0] data_i,
   input logic [DW-1:0] out_o,
   input logic          out_vld_o,
   input logic [DW-1:0] reg_a_o,
   input logic [DW-1:0] reg_b_o,
   input logic [3:0]    flag_o,
   input logic          mode_o
);

   p_emit_src_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      out_vld_o |-> $past(cmd_vld_i && cmd_i == 4'd2));

   p_emit_val_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      out_vld_o |-> out_o == $past(reg_a_o));

   p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cmd_vld_i || cmd_i > 4'd9) |=>
         ($stable(reg_a_o) && $stable(reg_b_o) && $stable(flag_o) && $stable(mode_o)));

   p_load_a_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_vld_i && cmd_i == 4'd0) |=> reg_a_o == $past(data_i));

   p_load_b_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_vld_i && cmd_i == 4'd1) |=> reg_b_o == $past(data_i));

   p_copy_b_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_vld_i && cmd_i == 4'd3) |=> reg_a_o == $past(reg_b_o));

   p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_vld_i && (cmd_i < 4'd5 || cmd_i == 4'd9)) |=> $stable(flag_o));

   p_logic_clr_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_vld_i && (cmd_i == 4'd7 || cmd_i == 4'd8)) |=> (!flag_o[3] && !flag_o[0]));

   p_mode_load_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_vld_i && cmd_i == 4'd9) |=> mode_o == $past(data_i[0]));

   generate
      if (SAT_EN) begin : g_sat_chk
         p_sat_add_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode_o && cmd_vld_i && cmd_i == 4'd5) |=> reg_a_o >= $past(reg_a_o));
         p_sat_sub_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode_o && cmd_vld_i && cmd_i == 4'd6) |=> reg_a_o <= $past(reg_a_o));
      end
   endgenerate

endmodule

bind nib_cmd_alu nca_checker #(.DW(DW), .SAT_EN(SAT_EN)) u_nca_checker (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .cmd_vld_i (cmd_vld_i),
   .cmd_i     (cmd_i),
   .data_i    (data_i),
   .out_o     (out_o),
   .out_vld_o (out_vld_o),
   .reg_a_o   (reg_a_o),
   .reg_b_o   (reg_b_o),
   .flag_o    (flag_o),
   .mode_o    (mode_o)
);

// File: tb/nib_cmd_alu_bench.sv
module nib_cmd_alu_bench;

   logic       clk = 1'b0;
   logic       rst_i;
   logic       cmd_vld_i;
   logic [3:0] cmd_i;
   logic [3:0] data_i;
   logic [7:0] dbg_idx_i;
   logic [3:0] out_o;
   logic       out_vld_o;
   logic [3:0] dbg_data_o;
   logic [3:0] reg_a_o;
   logic [3:0] reg_b_o;
   logic [3:0] flag_o;
   logic       mode_o;

   int n_checks = 0;
   int n_fails  = 0;

   // bench model state
   int m_a, m_b, m_f, m_m, m_out, m_vld;

   always #4 clk = ~clk;

   nib_cmd_alu u_nib_cmd_alu (
      .clk_i      (clk),
      .rst_i      (rst_i),
      .cmd_vld_i  (cmd_vld_i),
      .cmd_i      (cmd_i),
      .data_i     (data_i),
      .dbg_idx_i  (dbg_idx_i),
      .out_o      (out_o),
      .out_vld_o  (out_vld_o),
      .dbg_data_o (dbg_data_o),
      .reg_a_o    (reg_a_o),
      .reg_b_o    (reg_b_o),
      .flag_o     (flag_o),
      .mode_o     (mode_o)
   );

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sgn(int v);
      return (v > 7) ? v - 16 : v;
   endfunction

   function automatic string tag_a(bit v, int c, int mode);
      if (!v || c > 9) return "R2";
      case (c)
         0, 1: return "R3";
         2: return "R5";
         3, 4: return "R4";
         5, 6: return (mode != 0) ? "R9" : "R6";
         7, 8: return "R7";
         default: return "R10";
      endcase
   endfunction

   // Update the bench model for one clock edge.
   task automatic model(bit r, bit v, int c, int d);
      int s, raw, cy, ov, res;
      if (r) begin
         m_a = 0; m_b = 0; m_f = 0; m_m = 0; m_out = 0; m_vld = 0;
         return;
      end
      m_vld = (v && c == 2) ? 1 : 0;
      if (m_vld != 0) m_out = m_a;
      if (!v || c > 9) return;
      case (c)
         0: m_a = d;
         1: m_b = d;
         3: m_a = m_b;
         4: m_a = m_f;
         9: m_m = d % 2;
         5, 6, 7, 8: begin
            cy = 0; ov = 0;
            if (c == 5) begin
               s = m_a + m_b; raw = s % 16; cy = (s > 15) ? 1 : 0;
               s = sgn(m_a) + sgn(m_b); ov = (s > 7 || s < -8) ? 1 : 0;
               res = (m_m != 0 && cy != 0) ? 15 : raw;
            end else if (c == 6) begin
               s = m_a - m_b; raw = (s + 16) % 16; cy = (m_a >= m_b) ? 1 : 0;
               s = sgn(m_a) - sgn(m_b); ov = (s > 7 || s < -8) ? 1 : 0;
               res = (m_m != 0 && cy == 0) ? 0 : raw;
            end else begin
               raw = (c == 7) ? (m_a & m_b) : (m_a | m_b);
               res = raw;
            end
            m_f = ov * 8 + ((raw >= 8) ? 4 : 0) + ((raw == 0) ? 2 : 0) + cy;
            m_a = res;
         end
         default: ;
      endcase
   endtask

   function automatic int exp_dbg(int idx);
      case (idx)
         0: return m_a;
         1: return m_b;
         2: return m_m;
         3: return m_f;
         default: return 0;
      endcase
   endfunction

   task automatic step(bit r, bit v, int c, int d, int idx);
      string ta;
      int pm;
      rst_i = r; cmd_vld_i = v; cmd_i = 4'(c); data_i = 4'(d); dbg_idx_i = 8'(idx);
      pm = m_m;
      @(posedge clk);
      model(r, v, c, d);
      @(negedge clk);
      ta = r ? "R1" : tag_a(v, c, pm);
      check(ta, "reg A", int'(reg_a_o), m_a);
      check(r ? "R1" : ((v && c == 1) ? "R3" : "R2"), "reg B", int'(reg_b_o), m_b);
      check(r ? "R1" : ((pm != 0 && v && (c == 5 || c == 6)) ? "R9" : "R8"),
            "flags", int'(flag_o), m_f);
      check(r ? "R1" : "R10", "mode", int'(mode_o), m_m);
      check(r ? "R1" : "R5", "out valid", int'(out_vld_o), m_vld);
      if (r || m_vld != 0) check(r ? "R1" : "R5", "out bus", int'(out_o), m_out);
      check("R11", "debug read", int'(dbg_data_o), exp_dbg(idx));
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
   endtask

   initial begin
      #(8 * 150000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1b3d_0057));
      m_a = 0; m_b = 0; m_f = 0; m_m = 0; m_out = 0; m_vld = 0;
      rst_i = 1'b1; cmd_vld_i = 1'b0; cmd_i = '0; data_i = '0; dbg_idx_i = '0;
      @(negedge clk);
      // R1: reset state
      step(1, 1, 0, 9, 0);
      step(1, 0, 0, 0, 3);
      // R6/R8: signed overflow 7+1
      step(0, 1, 0, 7, 0);
      step(0, 1, 1, 1, 1);
      step(0, 1, 5, 0, 3);            // A=8, flags 1100
      check("R8", "overflow flag field", int'(flag_o), 12);
      // R6: carry at 15+1 wraps to 0, flags 0011
      step(0, 1, 0, 15, 0);
      step(0, 1, 5, 0, 3);
      check("R6", "wrap add", int'(reg_a_o), 0);
      // R9: saturating add and subtract
      step(0, 1, 9, 1, 2);
      step(0, 1, 0, 15, 0);
      step(0, 1, 5, 0, 0);
      check("R9", "saturated add", int'(reg_a_o), 15);
      step(0, 1, 0, 3, 0);
      step(0, 1, 1, 5, 1);
      step(0, 1, 6, 0, 3);
      check("R9", "saturated sub", int'(reg_a_o), 0);
      // R10: upper operand bits ignored
      step(0, 1, 9, 2, 2);
      check("R10", "mode from bit 0", int'(mode_o), 0);
      step(0, 1, 9, 15, 2);
      // R2: illegal code and idle strobe
      step(0, 1, 12, 6, 0);
      step(0, 0, 0, 6, 0);
      // R4 / R5: copy flag, back-to-back emits
      step(0, 1, 4, 0, 0);
      step(0, 1, 2, 0, 0);
      step(0, 1, 2, 0, 0);
      step(0, 1, 7, 0, 3);
      step(0, 0, 2, 0, 3);
      // R11: out-of-range indices
      step(0, 0, 0, 0, 4);
      step(0, 0, 0, 0, 255);
      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         bit r, v;
         int c, d, idx;
         r   = ($urandom % 100) < 1;
         v   = ($urandom % 100) < 85;
         c   = int'($urandom % 16);
         d   = int'($urandom % 16);
         if (c == 9 && ($urandom % 4) != 0) d = int'($urandom % 2);
         idx = (($urandom % 10) == 0) ? int'($urandom % 256) : int'($urandom % 5);
         step(r, v, c, d, idx);
      end
      summary();
      $finish;
   end

endmodule